// File: doc/BRIEF.md
# Parallel Slave Bus Port

This block gives an external byte-wide microprocessor an asynchronous mailbox into the local clock domain. The external side drives active-low chip-select, read and write strobes. The local side sees one address, but behind it there are two 8-bit latches. A local write loads the outbound latch. A local read returns the inbound latch, which holds the last byte that the external master wrote.

The external strobes and data lines pass through two-flop synchronizers. A transfer is active while the synchronized chip-select and the matching strobe are both low. It is complete on the first cycle in which that pair is no longer both low.

Three status flags track the mailbox:
- inbound full
- outbound full
- sticky inbound overflow

A latched completion flag is set when either kind of external transfer finishes. The flag is gated by a local enable to form the interrupt. The block drives the external data bus only while a synchronized external read is in progress and the port mode is enabled. The external master must hold the data lines stable for the whole write strobe.

Top module: `pbus_slave_port`

## Requirements
- R1: An external write (chip-select and write strobe both low) captures the byte on `ext_data_i` into the inbound latch. After the write completes, `host_rdata_o` shows that byte.
- R2: After the strobes of an external write are released, `ibf_o` and `irq_flag_o` are set together on the third rising clock edge. They are still clear after the second edge.
- R3: Once set, `ibf_o` is cleared only by a one-cycle `host_rd_i` pulse. While idle it stays set.
- R4: When an external write completes while `ibf_o` is already set, `ovf_o` is set. It stays set across local reads and idle cycles, and only a `host_clr_ovf_i` pulse clears it.
- R5: While an external read (chip-select and read strobe both low) is active and the mode is enabled, `ext_data_oe_o` is 1 and `ext_data_o` carries the outbound latch. `obf_o` clears at the start of the read.
- R6: Completion of an external read sets `irq_flag_o` and releases the bus (`ext_data_oe_o` = 0). `obf_o` stays clear until a `host_wr_i` pulse loads the outbound latch, which sets `obf_o`.
- R7: While `mode_en_i` is 0:
  - `ibf_o` and `obf_o` are held clear, and `ovf_o` keeps its value.
  - External strobes have no effect on the latches or flags.
  - The bus is not driven.
- R8: `irq_flag_o` stays set until a `host_clr_irq_i` pulse. `irq_o` equals `irq_flag_o` AND the enable bit that is loaded from `host_ie_i` on a `host_ie_wr_i` pulse. The enable bit resets to 0.
- R9: A `host_rd_i` pulse in the same cycle that an external write completes leaves `ibf_o` set. If `ibf_o` was set before, `ovf_o` is also set.
- R10: Write or read strobes with chip-select high do nothing: the latch, the flags and the bus stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_en_i | input | 1 | Port mode enable |
| ext_cs_ni | input | 1 | External chip-select, active low, asynchronous |
| ext_wr_ni | input | 1 | External write strobe, active low, asynchronous |
| ext_rd_ni | input | 1 | External read strobe, active low, asynchronous |
| ext_data_i | input | 8 | External data bus, inbound |
| ext_data_o | output | 8 | External data bus, outbound |
| ext_data_oe_o | output | 1 | Bus output enable |
| host_wr_i | input | 1 | Local write of the outbound latch |
| host_wdata_i | input | 8 | Local write data |
| host_rd_i | input | 1 | Local read of the inbound latch |
| host_rdata_o | output | 8 | Inbound latch contents |
| host_clr_ovf_i | input | 1 | Clear overflow flag |
| host_clr_irq_i | input | 1 | Clear completion flag |
| host_ie_wr_i | input | 1 | Load interrupt enable |
| host_ie_i | input | 1 | Interrupt enable value |
| ibf_o | output | 1 | Inbound full |
| obf_o | output | 1 | Outbound full |
| ovf_o | output | 1 | Inbound overflow, sticky |
| irq_flag_o | output | 1 | Latched completion flag |
| irq_o | output | 1 | Gated interrupt |

## Verification
The hardest case to reach is a local read that lands in exactly the same clock cycle as the completion of an external write. Reaching it needs the synchronizer latency counted edge by edge. The stimulus releases the strobes on a falling edge and raises `host_rd_i` on the second falling edge after the release. That places the read pulse on the third rising edge, where the completion fires. The same edge counting gives the exact-cycle check of R2, and full 256-value sweeps cover both data directions.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic ibf;
    logic obf;
    logic ovf;
    logic irq;
  } pbus_flags_t;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned WIDTH     = 1,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[g] <= RST_VAL;
      else if (g == 0) stage_q[g] <= d_i;
      else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pbus_strobe_track.sv
module pbus_strobe_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cs_n_i,
  input  logic stb_n_i,
  output logic active_o,
  output logic start_o,
  output logic end_o
);
  logic active_q;

  assign active_o = en_i & ~cs_n_i & ~stb_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_o;
  end

  assign start_o = active_o & ~active_q;
  // completion only counts while enabled; disabling mid-strobe drops it
  assign end_o   = en_i & active_q & ~active_o;

  a_r7_no_end_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !end_o && !start_o);
endmodule

// File: rtl/pbus_flags.sv
module pbus_flags
  import pbus_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        wr_end_i,
  input  logic        rd_start_i,
  input  logic        rd_end_i,
  input  logic        host_wr_i,
  input  logic        host_rd_i,
  input  logic        clr_ovf_i,
  input  logic        clr_irq_i,
  output pbus_flags_t flags_o
);
  pbus_flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (!en_i)          q.ibf <= 1'b0;
      else if (wr_end_i)  q.ibf <= 1'b1;   // set beats local read
      else if (host_rd_i) q.ibf <= 1'b0;

      if (!en_i)           q.obf <= 1'b0;
      else if (host_wr_i)  q.obf <= 1'b1;
      else if (rd_start_i) q.obf <= 1'b0;

      if (wr_end_i && q.ibf) q.ovf <= 1'b1;
      else if (clr_ovf_i)    q.ovf <= 1'b0;

      if (wr_end_i || rd_end_i) q.irq <= 1'b1;
      else if (clr_irq_i)       q.irq <= 1'b0;
    end
  end

  assign flags_o = q;

  a_r3_ibf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.ibf && !host_rd_i && en_i) |=> q.ibf);
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.ovf && !clr_ovf_i) |=> q.ovf);
  a_r6_obf_stays_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q.obf && !host_wr_i) |=> !q.obf);
  a_r7_disabled_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!q.ibf && !q.obf));
  a_r8_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.irq && !clr_irq_i) |=> q.irq);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_end_i && host_rd_i) |=> q.ibf);
endmodule

// File: rtl/pbus_slave_port.sv
module pbus_slave_port
  import pbus_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_en_i,
  input  logic          ext_cs_ni,
  input  logic          ext_wr_ni,
  input  logic          ext_rd_ni,
  input  logic [DW-1:0] ext_data_i,
  output logic [DW-1:0] ext_data_o,
  output logic          ext_data_oe_o,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          host_rd_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          host_clr_ovf_i,
  input  logic          host_clr_irq_i,
  input  logic          host_ie_wr_i,
  input  logic          host_ie_i,
  output logic          ibf_o,
  output logic          obf_o,
  output logic          ovf_o,
  output logic          irq_flag_o,
  output logic          irq_o
);
  localparam int unsigned CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_s;
  logic [DW-1:0]     data_s;
  logic              wr_act, wr_start, wr_end;
  logic              rd_act, rd_start, rd_end;
  logic [DW-1:0]     in_q, out_q;
  logic              ie_q;
  pbus_flags_t       flags;

  pbus_sync #(.WIDTH(CTRL_W), .STAGES(STAGES), .RST_VAL({CTRL_W{1'b1}})) u_sync_ctrl (
    .clk_i, .rst_ni,
    .d_i({ext_cs_ni, ext_wr_ni, ext_rd_ni}),
    .q_o(ctrl_s)
  );

  // data lags by the same depth as the strobes
  pbus_sync #(.WIDTH(DW), .STAGES(STAGES), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i(ext_data_i), .q_o(data_s)
  );

  pbus_strobe_track u_trk_wr (
    .clk_i, .rst_ni, .en_i(mode_en_i),
    .cs_n_i(ctrl_s[2]), .stb_n_i(ctrl_s[1]),
    .active_o(wr_act), .start_o(wr_start), .end_o(wr_end)
  );

  pbus_strobe_track u_trk_rd (
    .clk_i, .rst_ni, .en_i(mode_en_i),
    .cs_n_i(ctrl_s[2]), .stb_n_i(ctrl_s[0]),
    .active_o(rd_act), .start_o(rd_start), .end_o(rd_end)
  );

  pbus_flags u_flags (
    .clk_i, .rst_ni, .en_i(mode_en_i),
    .wr_end_i(wr_end), .rd_start_i(rd_start), .rd_end_i(rd_end),
    .host_wr_i, .host_rd_i,
    .clr_ovf_i(host_clr_ovf_i), .clr_irq_i(host_clr_irq_i),
    .flags_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      if (wr_act)       in_q  <= data_s;
      if (host_wr_i)    out_q <= host_wdata_i;
      if (host_ie_wr_i) ie_q  <= host_ie_i;
    end
  end

  assign ext_data_oe_o = rd_act;
  assign ext_data_o    = rd_act ? out_q : '0;
  assign host_rdata_o  = in_q;
  assign ibf_o         = flags.ibf;
  assign obf_o         = flags.obf;
  assign ovf_o         = flags.ovf;
  assign irq_flag_o    = flags.irq;
  assign irq_o         = flags.irq & ie_q;

  a_r1_latch_stable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_act |=> $stable(in_q));
  a_r5_oe_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_data_oe_o |-> mode_en_i);
  a_r5_obf_clear_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start && !host_wr_i) |=> !obf_o);
endmodule

// File: tb/pbus_slave_port_tb.sv
`timescale 1ns/1ps
module pbus_slave_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_en_i = 1'b0;
  logic       ext_cs_ni = 1'b1, ext_wr_ni = 1'b1, ext_rd_ni = 1'b1;
  logic [7:0] ext_data_i = '0;
  logic [7:0] ext_data_o;
  logic       ext_data_oe_o;
  logic       host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       host_clr_ovf_i = 1'b0, host_clr_irq_i = 1'b0;
  logic       host_ie_wr_i = 1'b0, host_ie_i = 1'b0;
  logic       ibf_o, obf_o, ovf_o, irq_flag_o, irq_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  pbus_slave_port u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk_i); sig = 1'b1;
    @(negedge clk_i); sig = 1'b0;
  endtask

  task automatic ext_write(input logic [7:0] d, input bit cs_on);
    @(negedge clk_i);
    ext_data_i = d; ext_cs_ni = !cs_on; ext_wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    ext_wr_ni = 1'b1; ext_cs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic ext_read(input bit cs_on, output logic oe, output logic [7:0] d);
    @(negedge clk_i);
    ext_cs_ni = !cs_on; ext_rd_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    oe = ext_data_oe_o; d = ext_data_o;
    ext_rd_ni = 1'b1; ext_cs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic host_load(input logic [7:0] d);
    @(negedge clk_i); host_wdata_i = d; host_wr_i = 1'b1;
    @(negedge clk_i); host_wr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic       oe;
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({ibf_o, obf_o, ovf_o, irq_flag_o, irq_o, ext_data_oe_o} == 6'b0, "R8 reset flags",
          {ibf_o, obf_o, ovf_o, irq_flag_o, irq_o, ext_data_oe_o}, 0);
    mode_en_i = 1'b1;

    // R1/R3 sweep over every inbound byte
    for (int v = 0; v < 256; v++) begin
      ext_write(v[7:0], 1'b1);
      check(host_rdata_o == v[7:0], "R1 inbound byte", host_rdata_o, v);
      check(ibf_o && irq_flag_o, "R3 ibf set after write", ibf_o, 1);
      pulse(host_rd_i);
      check(!ibf_o, "R3 ibf cleared by local read", ibf_o, 0);
      pulse(host_clr_irq_i);
    end
    check(!ovf_o, "R4 no overflow when drained", ovf_o, 0);

    // R2 exact latency
    @(negedge clk_i);
    ext_data_i = 8'h3c; ext_cs_ni = 1'b0; ext_wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    ext_wr_ni = 1'b1; ext_cs_ni = 1'b1;
    repeat (2) @(posedge clk_i); #1;
    check(!ibf_o && !irq_flag_o, "R2 still clear after 2 edges", {ibf_o, irq_flag_o}, 0);
    @(posedge clk_i); #1;
    check(ibf_o && irq_flag_o, "R2 set on 3rd edge", {ibf_o, irq_flag_o}, 3);

    // R3 hold while idle
    repeat (10) @(negedge clk_i);
    check(ibf_o, "R3 ibf holds idle", ibf_o, 1);

    // R8 gating
    check(irq_flag_o && !irq_o, "R8 masked irq", {irq_flag_o, irq_o}, 2);
    @(negedge clk_i); host_ie_i = 1'b1; host_ie_wr_i = 1'b1;
    @(negedge clk_i); host_ie_wr_i = 1'b0;
    check(irq_o, "R8 enabled irq", irq_o, 1);
    repeat (5) @(negedge clk_i);
    check(irq_flag_o, "R8 flag latched", irq_flag_o, 1);
    pulse(host_clr_irq_i);
    check(!irq_flag_o && !irq_o, "R8 cleared", {irq_flag_o, irq_o}, 0);

    // R4 overflow: ibf still set from 0x3c
    ext_write(8'ha5, 1'b1);
    check(ovf_o, "R4 overflow set", ovf_o, 1);
    check(host_rdata_o == 8'ha5, "R1 newest byte kept", host_rdata_o, 8'ha5);
    pulse(host_rd_i);
    repeat (5) @(negedge clk_i);
    check(ovf_o && !ibf_o, "R4 ovf sticky across read", {ovf_o, ibf_o}, 2);
    pulse(host_clr_ovf_i);
    check(!ovf_o, "R4 ovf cleared", ovf_o, 0);
    pulse(host_clr_irq_i);

    // R9 same-cycle read and completion, ibf already set
    ext_write(8'h11, 1'b1);
    check(ibf_o && !ovf_o, "R9 setup", {ibf_o, ovf_o}, 2);
    @(negedge clk_i);
    ext_data_i = 8'h22; ext_cs_ni = 1'b0; ext_wr_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    ext_wr_ni = 1'b1; ext_cs_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    host_rd_i = 1'b1;
    @(negedge clk_i); host_rd_i = 1'b0;
    check(ibf_o, "R9 ibf stays set", ibf_o, 1);
    check(ovf_o, "R9 overflow flagged", ovf_o, 1);
    check(host_rdata_o == 8'h22, "R9 data", host_rdata_o, 8'h22);
    pulse(host_rd_i);
    pulse(host_clr_ovf_i);
    pulse(host_clr_irq_i);

    // R5/R6 outbound sweep
    for (int v = 0; v < 256; v++) begin
      host_load(v[7:0]);
      check(obf_o, "R6 obf set by local write", obf_o, 1);
      ext_read(1'b1, oe, d);
      check(oe && d == v[7:0], "R5 bus drives outbound", {oe, d}, {1'b1, v[7:0]});
      check(!obf_o && irq_flag_o, "R6 obf clear, irq set", {obf_o, irq_flag_o}, 1);
      check(!ext_data_oe_o, "R6 bus released", ext_data_oe_o, 0);
      pulse(host_clr_irq_i);
    end
    repeat (6) @(negedge clk_i);
    check(!obf_o, "R6 obf stays clear", obf_o, 0);

    // R5 obf clears at read start, before release
    host_load(8'h5a);
    @(negedge clk_i); ext_cs_ni = 1'b0; ext_rd_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check(!obf_o && ext_data_o == 8'h5a, "R5 obf clear during read", {obf_o, ext_data_o}, 8'h5a);
    ext_rd_ni = 1'b1; ext_cs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    pulse(host_clr_irq_i);

    // R10 chip-select high
    ext_write(8'hee, 1'b0);
    check(host_rdata_o == 8'h22 && !ibf_o && !irq_flag_o, "R10 write ignored",
          host_rdata_o, 8'h22);
    host_load(8'h77);
    ext_read(1'b0, oe, d);
    check(!oe && obf_o && !irq_flag_o, "R10 read ignored", {oe, obf_o, irq_flag_o}, 2);

    // R7 disable: obf set, make ovf set first
    ext_write(8'h01, 1'b1);
    ext_write(8'h02, 1'b1);
    pulse(host_clr_irq_i);
    @(negedge clk_i); mode_en_i = 1'b0;
    @(negedge clk_i);
    check(!ibf_o && !obf_o && ovf_o, "R7 flags on disable", {ibf_o, obf_o, ovf_o}, 1);
    ext_write(8'h99, 1'b1);
    check(host_rdata_o == 8'h02 && !irq_flag_o && !ibf_o, "R7 write ignored",
          host_rdata_o, 8'h02);
    ext_read(1'b1, oe, d);
    check(!oe && !irq_flag_o, "R7 read ignored", {oe, irq_flag_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule